// File: doc/BRIEF.md
# Capture frame buffer ring manager

This block keeps the slot bookkeeping for a video input writer that fills a small ring of frame buffers. At start it works out how many slots fit in the memory it was given and latches the layout. It then steps a write index on every frame event. Each completed slot is handed to a display consumer through a one-cycle publish strobe. The next slot's canvas identifier is presented as the new write target.

Only the index arithmetic and address generation live here. Memory traffic, canvas descriptor tables and the display pipeline are outside the block. Each canvas table is modelled as a base identifier plus the slot index, and a device-select input picks one of two bases.

In capture mode a frame event does not advance the ring. Instead it selects the most recently completed slot and returns that slot's number and byte address. If the consumer currently holds the most recently completed slot, the block picks the slot after the write slot instead.

Top module: `fbr_ring_mgr`

## Requirements
- R1: After reset the block is idle:
  - `running_o`, `pub_vld_o`, `prog_vld_o`, `cap_vld_o` and `wrap_o` are 0.
  - `slot_cnt_o` equals POOL_SLOTS (6).
  - `rd_idx_o` is 0xFF-(POOL_SLOTS+2), which is 0xF7.
  - `wr_canvas_o` is 0xFF.
- R2: A start latches the slot count as the smaller of POOL_SLOTS and floor((mem_size-hdr_size)/slot_size). The count is 0 when mem_size is below hdr_size.
- R3: An accepted start does the following:
  - sets `running_o`;
  - sets the write index to the sentinel 0xFF, so that `wr_canvas_o` reads 0xFF;
  - sets the read index to 0xFF-(count+2);
  - clears `wrap_o`.
  A start while running changes none of these.
- R4: The first accepted frame event after start does three things. It sets the write index to 0 and pulses `prog_vld_o`. It does not pulse `pub_vld_o`.
- R5: Every later accepted non-capture frame event does the following, one clock after the event:
  - pulses `pub_vld_o` for exactly one cycle, with `pub_slot_o` set to the slot being written before the event;
  - advances the write index by one, wrapping to 0 at the slot count;
  - sets `wrap_o` on the first wrap.
- R6: Canvas mapping returns a value that depends on the slot index:
  - for an index below the slot count, the selected base plus the index, where `dev_sel_i`=1 selects `canvas_base1_i` and 0 selects `canvas_base0_i`;
  - for any other index, 0xFF.
- R7: In capture mode the candidate slot is the one before the write slot, with write index 0 giving count-1. If the candidate equals the read index, the slot after the write slot is used instead, with write index count-1 giving 0.
- R8: A capture event produces its outputs one clock later, and leaves the write index unchanged:
  - `cap_vld_o` pulses;
  - `cap_addr_o` is base+hdr_size+slot×slot_size, using the values latched at start;
  - `cap_size_o` equals the latched slot size.
- R9: A frame event has no effect in any of these cases: the block is not running, `act_width_i` is 0, or the slot count is 0.
- R10: `stop_i` clears `running_o`, and it wins over a start or frame event in the same cycle.
- R11: `rd_load_i` loads `rd_idx_i` into the read index, and the loaded value shows on `rd_idx_o` the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request |
| stop_i | input | 1 | Stop request |
| frame_i | input | 1 | Per-frame event pulse |
| cap_mode_i | input | 1 | Capture mode select |
| dev_sel_i | input | 1 | Canvas table select |
| act_width_i | input | 12 | Active pixel width; 0 blocks frame events |
| rd_load_i | input | 1 | Load consumer read index |
| rd_idx_i | input | 8 | Consumer read index value |
| base_addr_i | input | ADDR_W | Buffer memory base address |
| mem_size_i | input | ADDR_W | Buffer memory size in bytes |
| hdr_size_i | input | ADDR_W | Reserved header size in bytes |
| slot_size_i | input | ADDR_W | Per-slot buffer size in bytes |
| canvas_base0_i | input | 8 | First canvas table base identifier |
| canvas_base1_i | input | 8 | Second canvas table base identifier |
| running_o | output | 1 | Block started |
| slot_cnt_o | output | CNT_W | Latched usable slot count |
| wr_idx_o | output | 8 | Current write index (0xFF when not primed) |
| rd_idx_o | output | 8 | Current read index |
| wrap_o | output | 1 | Write index has wrapped |
| wr_canvas_o | output | 8 | Canvas identifier of the write slot |
| prog_vld_o | output | 1 | New write target programmed |
| pub_vld_o | output | 1 | Publish strobe |
| pub_slot_o | output | 8 | Published slot index |
| pub_canvas_o | output | 8 | Canvas identifier of the published slot |
| cap_vld_o | output | 1 | Capture result strobe |
| cap_slot_o | output | 8 | Captured slot index |
| cap_addr_o | output | ADDR_W | Captured slot byte address |
| cap_size_o | output | ADDR_W | Captured buffer size |

## Verification
The bench checks the priming frame, since a design that published on it would hand the consumer slot 0xFF. It follows the write index across the wrap, where an off-by-one comparison would either publish a slot equal to the count or skip slot count-1. Capture is run against a read index that collides with the candidate at both ring ends. Here a design that ignored the collision would return the slot the consumer holds, and one that wrapped wrongly would return an out-of-range slot. The slot count is checked with a remainder, an ample memory and a memory smaller than the header. This exposes a rounding or clamp error, or a count that underflows and admits frames.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  localparam int IDX_W = 8;
  localparam logic [IDX_W-1:0] SENTINEL = 8'hFF;

  // Slot index to canvas identifier; out-of-range indices map to 0xFF.
  function automatic logic [IDX_W-1:0] fbr_canvas(input logic [IDX_W-1:0] idx,
                                                  input logic [IDX_W-1:0] cnt,
                                                  input logic [IDX_W-1:0] base);
    return (idx < cnt) ? IDX_W'(base + idx) : SENTINEL;
  endfunction

  // Ring advance with wrap at the slot count.
  function automatic logic [IDX_W-1:0] fbr_next(input logic [IDX_W-1:0] idx,
                                                input logic [IDX_W-1:0] cnt);
    return (IDX_W'(idx + 1) >= cnt) ? '0 : IDX_W'(idx + 1);
  endfunction

  // Capture choice: newest completed slot, else the one after the writer.
  function automatic logic [IDX_W-1:0] fbr_cap_pick(input logic [IDX_W-1:0] wr,
                                                    input logic [IDX_W-1:0] rd,
                                                    input logic [IDX_W-1:0] cnt);
    logic [IDX_W-1:0] prev;
    prev = (wr == '0) ? IDX_W'(cnt - 1) : IDX_W'(wr - 1);
    if (prev != rd) return prev;
    return (wr == IDX_W'(cnt - 1)) ? '0 : IDX_W'(wr + 1);
  endfunction
endpackage

// File: rtl/fbr_slot_count.sv
module fbr_slot_count #(
  parameter int POOL_SLOTS = 6,
  parameter int ADDR_W     = 32,
  localparam int CNT_W     = $clog2(POOL_SLOTS + 1)
) (
  input  logic [ADDR_W-1:0] mem_size,
  input  logic [ADDR_W-1:0] hdr_size,
  input  logic [ADDR_W-1:0] slot_size,
  output logic [CNT_W-1:0]  count
);
  localparam int PW = ADDR_W + CNT_W;
  logic [ADDR_W-1:0]     avail;
  logic [POOL_SLOTS-1:0] fits;

  assign avail = (mem_size >= hdr_size) ? (mem_size - hdr_size) : '0;

  // k slots fit when k*slot_size does not exceed the space left
  for (genvar k = 1; k <= POOL_SLOTS; k++) begin : g_fit
    logic [PW-1:0] need;
    assign need        = PW'(slot_size) * PW'(k);
    assign fits[k-1]   = (mem_size >= hdr_size) && (PW'(avail) >= need);
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < POOL_SLOTS; i++)
      if (fits[i]) count = CNT_W'(i + 1);
  end
endmodule

// File: rtl/fbr_cap_addr.sv
module fbr_cap_addr #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] hdr,
  input  logic [ADDR_W-1:0] size,
  input  logic [IDX_W-1:0]  slot,
  output logic [ADDR_W-1:0] addr
);
  assign addr = base + hdr + ADDR_W'(size * ADDR_W'(slot));
endmodule

// File: rtl/fbr_ring_mgr.sv
module fbr_ring_mgr
  import fbr_pkg::*;
#(
  parameter int POOL_SLOTS = 6,
  parameter int ADDR_W     = 32,
  localparam int CNT_W     = $clog2(POOL_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              frame_i,
  input  logic              cap_mode_i,
  input  logic              dev_sel_i,
  input  logic [11:0]       act_width_i,
  input  logic              rd_load_i,
  input  logic [7:0]        rd_idx_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [ADDR_W-1:0] mem_size_i,
  input  logic [ADDR_W-1:0] hdr_size_i,
  input  logic [ADDR_W-1:0] slot_size_i,
  input  logic [7:0]        canvas_base0_i,
  input  logic [7:0]        canvas_base1_i,
  output logic              running_o,
  output logic [CNT_W-1:0]  slot_cnt_o,
  output logic [7:0]        wr_idx_o,
  output logic [7:0]        rd_idx_o,
  output logic              wrap_o,
  output logic [7:0]        wr_canvas_o,
  output logic              prog_vld_o,
  output logic              pub_vld_o,
  output logic [7:0]        pub_slot_o,
  output logic [7:0]        pub_canvas_o,
  output logic              cap_vld_o,
  output logic [7:0]        cap_slot_o,
  output logic [ADDR_W-1:0] cap_addr_o,
  output logic [ADDR_W-1:0] cap_size_o
);
  localparam logic [IDX_W-1:0] RD_RST = IDX_W'(8'hFF - (POOL_SLOTS + 2));

  logic              running_q, wrap_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  wr_idx_q, rd_idx_q;
  logic [ADDR_W-1:0] base_q, hdr_q, size_q;
  logic              pub_vld_q, prog_vld_q, cap_vld_q;
  logic [IDX_W-1:0]  pub_slot_q, pub_canvas_q, cap_slot_q;
  logic [ADDR_W-1:0] cap_addr_q;

  // Named internal events
  logic              start_acc, frame_acc, prime_ev, adv_ev, cap_ev;
  logic [CNT_W-1:0]  cnt_new;
  logic [IDX_W-1:0]  cnt8, cnt_new8, wr_next, cap_pick, canvas_base;
  logic [ADDR_W-1:0] cap_addr_w;

  assign cnt8        = IDX_W'(cnt_q);
  assign cnt_new8    = IDX_W'(cnt_new);
  assign start_acc   = start_i && !stop_i && !running_q;
  assign frame_acc   = frame_i && !stop_i && running_q && (act_width_i != '0) && (cnt_q != '0);
  assign cap_ev      = frame_acc && cap_mode_i;
  assign prime_ev    = frame_acc && !cap_mode_i && (wr_idx_q == SENTINEL);
  assign adv_ev      = frame_acc && !cap_mode_i && (wr_idx_q != SENTINEL);
  assign wr_next     = fbr_next(wr_idx_q, cnt8);
  assign cap_pick    = fbr_cap_pick(wr_idx_q, rd_idx_q, cnt8);
  assign canvas_base = dev_sel_i ? canvas_base1_i : canvas_base0_i;

  fbr_slot_count #(.POOL_SLOTS(POOL_SLOTS), .ADDR_W(ADDR_W)) u_count (
    .mem_size (mem_size_i),
    .hdr_size (hdr_size_i),
    .slot_size(slot_size_i),
    .count    (cnt_new)
  );

  fbr_cap_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
    .base(base_q),
    .hdr (hdr_q),
    .size(size_q),
    .slot(cap_pick),
    .addr(cap_addr_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running_q    <= 1'b0;
      wrap_q       <= 1'b0;
      cnt_q        <= CNT_W'(POOL_SLOTS);
      wr_idx_q     <= SENTINEL;
      rd_idx_q     <= RD_RST;
      base_q       <= '0;
      hdr_q        <= '0;
      size_q       <= '0;
      pub_vld_q    <= 1'b0;
      prog_vld_q   <= 1'b0;
      cap_vld_q    <= 1'b0;
      pub_slot_q   <= '0;
      pub_canvas_q <= '0;
      cap_slot_q   <= '0;
      cap_addr_q   <= '0;
    end else begin
      pub_vld_q  <= adv_ev;
      prog_vld_q <= prime_ev || adv_ev;
      cap_vld_q  <= cap_ev;
      if (stop_i) running_q <= 1'b0;
      if (rd_load_i) rd_idx_q <= rd_idx_i;
      if (start_acc) begin
        running_q <= 1'b1;
        cnt_q     <= cnt_new;
        wr_idx_q  <= SENTINEL;
        rd_idx_q  <= IDX_W'(8'hFF - cnt_new8 - 8'd2);
        wrap_q    <= 1'b0;
        base_q    <= base_addr_i;
        hdr_q     <= hdr_size_i;
        size_q    <= slot_size_i;
      end
      if (prime_ev) wr_idx_q <= '0;
      if (adv_ev) begin
        pub_slot_q   <= wr_idx_q;
        pub_canvas_q <= fbr_canvas(wr_idx_q, cnt8, canvas_base);
        wr_idx_q     <= wr_next;
        if (wr_next == '0) wrap_q <= 1'b1;
      end
      if (cap_ev) begin
        cap_slot_q <= cap_pick;
        cap_addr_q <= cap_addr_w;
      end
    end
  end

  assign running_o    = running_q;
  assign slot_cnt_o   = cnt_q;
  assign wr_idx_o     = wr_idx_q;
  assign rd_idx_o     = rd_idx_q;
  assign wrap_o       = wrap_q;
  assign wr_canvas_o  = fbr_canvas(wr_idx_q, cnt8, canvas_base);
  assign prog_vld_o   = prog_vld_q;
  assign pub_vld_o    = pub_vld_q;
  assign pub_slot_o   = pub_slot_q;
  assign pub_canvas_o = pub_canvas_q;
  assign cap_vld_o    = cap_vld_q;
  assign cap_slot_o   = cap_slot_q;
  assign cap_addr_o   = cap_addr_q;
  assign cap_size_o   = size_q;
endmodule

// File: rtl/fbr_ring_chk.sv
module fbr_ring_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             stop_i,
  input logic             frame_i,
  input logic             running_o,
  input logic [CNT_W-1:0] slot_cnt_o,
  input logic [7:0]       wr_idx_o,
  input logic [7:0]       rd_idx_o,
  input logic             pub_vld_o,
  input logic [7:0]       pub_slot_o,
  input logic             cap_vld_o,
  input logic [7:0]       cap_slot_o,
  input logic             prime_ev
);
  // R4: the priming frame never publishes
  p_prime_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    prime_ev |=> !pub_vld_o);

  // R5: a publish follows a frame event and names the previous write slot
  p_pub_after_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pub_vld_o |-> $past(frame_i) && $past(running_o) && (pub_slot_o == $past(wr_idx_o)));

  // R5: a primed write index stays inside the ring while running
  p_wr_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && wr_idx_o != 8'hFF) |-> (wr_idx_o < 8'(slot_cnt_o)));

  // R7: with more than two slots the capture never returns the reader's slot
  p_cap_avoids_reader_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_vld_o && slot_cnt_o > 2) |-> (cap_slot_o != $past(rd_idx_o)));

  // R3: a repeated start leaves the write index alone
  p_restart_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && start_i && !stop_i && !frame_i) |=> $stable(wr_idx_o));

  // R10: stop always clears running
  p_stop_idles_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !running_o);
endmodule

bind fbr_ring_mgr fbr_ring_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .stop_i    (stop_i),
  .frame_i   (frame_i),
  .running_o (running_o),
  .slot_cnt_o(slot_cnt_o),
  .wr_idx_o  (wr_idx_o),
  .rd_idx_o  (rd_idx_o),
  .pub_vld_o (pub_vld_o),
  .pub_slot_o(pub_slot_o),
  .cap_vld_o (cap_vld_o),
  .cap_slot_o(cap_slot_o),
  .prime_ev  (prime_ev)
);

// File: tb/fbr_ring_mgr_tb.sv
module fbr_ring_mgr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 3;

  logic        clk = 0, rst_n = 0;
  logic        start_i = 0, stop_i = 0, frame_i = 0, cap_mode_i = 0, dev_sel_i = 0;
  logic [11:0] act_width_i = 12'd720;
  logic        rd_load_i = 0;
  logic [7:0]  rd_idx_i = 0;
  logic [31:0] base_addr_i = 32'h8100_0000, mem_size_i = 0;
  logic [31:0] hdr_size_i = 32'h4000, slot_size_i = 32'h1000;
  logic [7:0]  canvas_base0_i = 8'h20, canvas_base1_i = 8'h40;
  logic        running_o, wrap_o, prog_vld_o, pub_vld_o, cap_vld_o;
  logic [CW-1:0] slot_cnt_o;
  logic [7:0]  wr_idx_o, rd_idx_o, wr_canvas_o, pub_slot_o, pub_canvas_o, cap_slot_o;
  logic [31:0] cap_addr_o, cap_size_o;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fbr_ring_mgr u_dut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic do_start(logic [31:0] mem);
    mem_size_i = mem; start_i = 1; cyc(); start_i = 0; cyc();
  endtask

  task automatic do_stop(); stop_i = 1; cyc(); stop_i = 0; cyc(); endtask

  task automatic frame(); frame_i = 1; cyc(); frame_i = 0; endtask

  task automatic t_reset();
    check("R1 running", running_o, 0);
    check("R1 cnt", slot_cnt_o, 6);
    check("R1 rd", rd_idx_o, 8'hF7);
    check("R1 canvas", wr_canvas_o, 8'hFF);
    check("R1 strobes", {pub_vld_o, prog_vld_o, cap_vld_o, wrap_o}, 0);
    frame(); cyc();
    check("R9 idle frame", {prog_vld_o, pub_vld_o, wr_idx_o}, {2'b00, 8'hFF});
  endtask

  task automatic t_count();
    do_start(32'h4000 + 3*32'h1000 + 5);
    check("R2 remainder", slot_cnt_o, 3);
    check("R3 rd init", rd_idx_o, 8'hFF - 5);
    check("R3 sentinel", wr_idx_o, 8'hFF);
    check("R3 running", running_o, 1);
    do_start(32'h0010_0000);
    check("R3 restart keeps cnt", slot_cnt_o, 3);
    do_stop();
    check("R10 stop", running_o, 0);
    do_start(32'h0010_0000);
    check("R2 clamp", slot_cnt_o, 6);
    do_stop();
    do_start(32'h3000);
    check("R2 short mem", slot_cnt_o, 0);
    frame(); cyc();
    check("R9 zero count", {prog_vld_o, wr_idx_o}, {1'b0, 8'hFF});
    do_stop();
  endtask

  task automatic t_ring();
    do_start(32'h4000 + 4*32'h1000);
    frame_i = 1; cyc(); frame_i = 0;
    check("R4 prime prog", prog_vld_o, 1);
    check("R4 prime no pub", pub_vld_o, 0);
    check("R4 idx0", wr_idx_o, 0);
    check("R6 canvas0", wr_canvas_o, 8'h20);
    for (int i = 0; i < 4; i++) begin
      frame();
      check("R5 pub", pub_vld_o, 1);
      check("R5 slot", pub_slot_o, i);
      check("R6 pub canvas", pub_canvas_o, 8'h20 + i);
      check("R5 idx", wr_idx_o, (i + 1) % 4);
      check("R5 wrap", wrap_o, (i == 3));
      cyc();
      check("R5 pulse", pub_vld_o, 0);
    end
    dev_sel_i = 1; cyc();
    check("R6 table1", wr_canvas_o, 8'h40);
    dev_sel_i = 0;
    act_width_i = 0; frame(); cyc();
    check("R9 zero width", {pub_vld_o, wr_idx_o}, {1'b0, 8'h00});
    act_width_i = 12'd720;
    stop_i = 1; frame_i = 1; cyc(); stop_i = 0; frame_i = 0;
    check("R10 stop wins", {pub_vld_o, running_o, wr_idx_o}, {2'b00, 8'h00});
    cyc();
  endtask

  task automatic t_capture();
    do_start(32'h4000 + 4*32'h1000);
    frame(); frame(); frame(); cyc();   // wr = 2
    cap_mode_i = 1;
    frame();
    check("R7 prev", cap_slot_o, 1);
    check("R8 addr", cap_addr_o, 32'h8100_0000 + 32'h4000 + 32'h1000);
    check("R8 size", cap_size_o, 32'h1000);
    check("R8 idx kept", wr_idx_o, 2);
    rd_idx_i = 1; rd_load_i = 1; cyc(); rd_load_i = 0;
    check("R11 load", rd_idx_o, 1);
    frame();
    check("R7 collide", cap_slot_o, 3);
    cap_mode_i = 0; frame(); cap_mode_i = 1;  // wr = 3
    rd_idx_i = 2; rd_load_i = 1; cyc(); rd_load_i = 0;
    frame();
    check("R7 wrap next", cap_slot_o, 0);
    check("R8 addr0", cap_addr_o, 32'h8100_4000);
    cap_mode_i = 0; frame(); cap_mode_i = 1;  // wr = 0
    frame();
    check("R7 wrap prev", cap_slot_o, 3);
    cap_mode_i = 0;
    do_stop();
  endtask

  initial begin
    fork
      begin
        repeat (3) cyc();
        rst_n = 1; cyc();
        t_reset();
        t_count();
        t_ring();
        t_capture();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule